// File: doc/BRIEF.md
# Circular Event Queue Writer

This block appends one 32-bit record to a ring of entries in memory for every push request it accepts. The record carries the event's 31-bit payload below a single generation bit. That bit flips each time the write index wraps back to the start of the ring. A consumer can therefore tell fresh entries from stale ones by comparing the generation bit, with no shared read pointer.

The block holds the state of one ring: a 60-bit base address, a size code, a write index and the current generation bit. Software loads all four through a configuration port while the block is idle. When a push is accepted, the block issues exactly one 32-bit write on a request/ready port. On success it advances the index modulo the ring length. A write that returns an error ends the push and leaves the ring state as it was, so a retry lands in the same slot. A one-cycle done pulse, together with an error flag, closes every push.

Top module: `evq_writer`

## Requirements
- R1: After reset the block is idle (busy_o, mem_req_o, done_o and done_err_o low), with base address 0, size code 0, index 0 and generation 0.
- R2: A push is accepted only in a cycle where the block is idle and cfg_we_i is low. A push_i seen while busy, or together with cfg_we_i, causes no memory write.
- R3: The record is {generation, push_data_i[30:0]}, with the generation in bit 31. It is sent big-endian: mem_data_o[7:0] carries record bits 31:24, mem_data_o[15:8] bits 23:16, mem_data_o[23:16] bits 15:8 and mem_data_o[31:24] bits 7:0.
- R4: mem_addr_o is the 60-bit sum of the base address and 4 times the index. The base address is {cfg_base_hi_i[27:0], cfg_base_lo_i[31:0]}, and a carry out of the low 32 bits propagates into the upper bits.
- R5: The ring holds 2^(size code + 10) entries. A size code above MAX_CODE (default 5) is treated as MAX_CODE.
- R6: After a write whose handshake has mem_err_i low, the index advances by one modulo the entry count.
- R7: When the advanced index is 0, the generation bit is inverted. It changes at no other time except a configuration load.
- R8: A write whose handshake has mem_err_i high leaves the index and the generation unchanged, so the next push writes the same address with the same generation.
- R9: busy_o rises in the cycle after acceptance and falls in the cycle after the handshake (mem_req_o and mem_ready_i both high). mem_req_o, mem_addr_o and mem_data_o are held stable until the handshake.
- R10: In the cycle after each handshake, done_o is high for exactly one cycle and done_err_o equals the mem_err_i value of that handshake.
- R11: cfg_we_i loads base, size code, index and generation only while the block is idle and is ignored while busy. The loaded index is reduced modulo the entry count of the loaded size code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Load ring configuration (idle only) |
| cfg_base_hi_i | input | 28 | Base address bits 59:32 |
| cfg_base_lo_i | input | 32 | Base address bits 31:0 |
| cfg_size_i | input | 4 | Size code; entries = 2^(code+10) |
| cfg_index_i | input | IDX_W (15) | Write index to load |
| cfg_gen_i | input | 1 | Generation bit to load |
| push_i | input | 1 | Push request |
| push_data_i | input | 31 | Event payload |
| busy_o | output | 1 | Push in progress |
| mem_req_o | output | 1 | Memory write request |
| mem_addr_o | output | 60 | Byte address of the entry |
| mem_data_o | output | 32 | Big-endian record |
| mem_ready_i | input | 1 | Memory accepts the write |
| mem_err_i | input | 1 | Write failed; valid with mem_ready_i |
| done_o | output | 1 | Push finished (one cycle) |
| done_err_o | output | 1 | Finished push failed |

## Verification
A wrong index shows up at the ports on the very next push, as a mem_addr_o that differs from the base plus four times the expected slot. A wrong generation bit shows up as a flipped bit in the record's most significant byte, which sits in the lowest data lane. Wrap faults, such as a wrong modulus, a missing generation toggle or a dropped carry into the upper base bits, stay hidden until the push that crosses the ring's end. The bench therefore walks full laps and lands pushes on the last slot for every size code. A fault that lets an error commit the index, or lets a busy-time request through, appears within one push as a skipped slot or an extra handshake.

// File: rtl/evq_pkg.sv
package evq_pkg;
  typedef enum logic [0:0] {
    ST_IDLE  = 1'b0,
    ST_WRITE = 1'b1
  } evq_state_e;

  localparam int HI_W   = 28;
  localparam int LO_W   = 32;
  localparam int ADDR_W = HI_W + LO_W;
  localparam int REC_W  = 32;
  localparam int DATA_W = REC_W - 1;
  localparam int ENTRY_SHIFT = 2;
endpackage

// File: rtl/evq_ring_state.sv
module evq_ring_state
  import evq_pkg::*;
#(
  parameter int CODE_W   = 4,
  parameter int MAX_CODE = 5,
  parameter int MIN_LOG2 = 10,
  localparam int IDX_W   = MAX_CODE + MIN_LOG2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [HI_W-1:0]   base_hi_i,
  input  logic [LO_W-1:0]   base_lo_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [IDX_W-1:0]  index_i,
  input  logic              gen_i,
  input  logic              commit_i,
  output logic [ADDR_W-1:0] base_o,
  output logic [IDX_W-1:0]  index_o,
  output logic              gen_o
);
  logic [ADDR_W-1:0] base_q;
  logic [CODE_W-1:0] code_q;
  logic [IDX_W-1:0]  index_q;
  logic              gen_q;
  logic [IDX_W-1:0]  mask_cur;
  logic [IDX_W-1:0]  mask_new;
  logic [CODE_W-1:0] code_new;
  logic [IDX_W-1:0]  index_nxt;

  function automatic logic [CODE_W-1:0] clamp_code(input logic [CODE_W-1:0] c);
    return (c > CODE_W'(MAX_CODE)) ? CODE_W'(MAX_CODE) : c;
  endfunction

  function automatic logic [IDX_W-1:0] mask_of(input logic [CODE_W-1:0] c);
    logic [IDX_W-1:0] m;
    for (int b = 0; b < IDX_W; b++) m[b] = (b < MIN_LOG2 + int'(c));
    return m;
  endfunction

  assign code_new  = clamp_code(code_i);
  assign mask_new  = mask_of(code_new);
  assign mask_cur  = mask_of(code_q);
  assign index_nxt = (index_q + IDX_W'(1)) & mask_cur;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q  <= '0;
      code_q  <= '0;
      index_q <= '0;
      gen_q   <= 1'b0;
    end else if (load_i) begin
      base_q  <= {base_hi_i, base_lo_i};
      code_q  <= code_new;
      index_q <= index_i & mask_new;
      gen_q   <= gen_i;
    end else if (commit_i) begin
      index_q <= index_nxt;
      if (index_nxt == '0) gen_q <= ~gen_q;
    end
  end

  assign base_o  = base_q;
  assign index_o = index_q;
  assign gen_o   = gen_q;

  a_r7_gen_only_on_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(gen_q) && !$past(load_i)) |-> (index_q == '0));

  a_r5_index_in_ring: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (index_q & ~mask_cur) == '0);

  a_r5_code_clamped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    code_q <= CODE_W'(MAX_CODE));
endmodule

// File: rtl/evq_entry_fmt.sv
module evq_entry_fmt
  import evq_pkg::*;
#(
  parameter int IDX_W = 15
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [IDX_W-1:0]  index_i,
  input  logic              gen_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [REC_W-1:0]  wdata_o
);
  localparam int BYTES = REC_W / 8;
  logic [REC_W-1:0] rec;

  assign rec    = {gen_i, data_i};
  assign addr_o = base_i + (ADDR_W'(index_i) << ENTRY_SHIFT);

  // lowest lane carries the most significant record byte
  for (genvar i = 0; i < BYTES; i++) begin : g_lane
    assign wdata_o[8*i +: 8] = rec[8*(BYTES-1-i) +: 8];
  end
endmodule

// File: rtl/evq_ctrl.sv
module evq_ctrl
  import evq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic push_i,
  input  logic cfg_we_i,
  input  logic mem_ready_i,
  input  logic mem_err_i,
  output logic accept_o,
  output logic load_o,
  output logic commit_o,
  output logic busy_o,
  output logic mem_req_o,
  output logic done_o,
  output logic done_err_o
);
  evq_state_e state_q, state_d;
  logic handshake;
  logic done_q, done_err_q;

  assign accept_o  = (state_q == ST_IDLE) && push_i && !cfg_we_i;
  assign load_o    = (state_q == ST_IDLE) && cfg_we_i;
  assign mem_req_o = (state_q == ST_WRITE);
  assign handshake = mem_req_o && mem_ready_i;
  assign commit_o  = handshake && !mem_err_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (accept_o)  state_d = ST_WRITE;
      ST_WRITE: if (handshake) state_d = ST_IDLE;
      default:                 state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      done_q     <= 1'b0;
      done_err_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      done_q     <= handshake;
      done_err_q <= handshake && mem_err_i;
    end
  end

  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = done_q;
  assign done_err_o = done_err_q;

  a_r9_req_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ready_i) |=> mem_req_o);

  a_r2_busy_needs_push: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(push_i && !cfg_we_i));

  a_r10_done_after_hs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(mem_req_o && mem_ready_i));

  a_r10_err_in_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_err_o |-> done_o);

  a_r10_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: rtl/evq_writer.sv
module evq_writer
  import evq_pkg::*;
#(
  parameter int CODE_W   = 4,
  parameter int MAX_CODE = 5,
  parameter int MIN_LOG2 = 10,
  localparam int IDX_W   = MAX_CODE + MIN_LOG2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [HI_W-1:0]   cfg_base_hi_i,
  input  logic [LO_W-1:0]   cfg_base_lo_i,
  input  logic [CODE_W-1:0] cfg_size_i,
  input  logic [IDX_W-1:0]  cfg_index_i,
  input  logic              cfg_gen_i,
  input  logic              push_i,
  input  logic [DATA_W-1:0] push_data_i,
  output logic              busy_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [REC_W-1:0]  mem_data_o,
  input  logic              mem_ready_i,
  input  logic              mem_err_i,
  output logic              done_o,
  output logic              done_err_o
);
  logic accept, load, commit;
  logic [ADDR_W-1:0] base;
  logic [IDX_W-1:0]  index;
  logic              gen;
  logic [DATA_W-1:0] data_q;

  evq_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (push_i),
    .cfg_we_i    (cfg_we_i),
    .mem_ready_i (mem_ready_i),
    .mem_err_i   (mem_err_i),
    .accept_o    (accept),
    .load_o      (load),
    .commit_o    (commit),
    .busy_o      (busy_o),
    .mem_req_o   (mem_req_o),
    .done_o      (done_o),
    .done_err_o  (done_err_o)
  );

  evq_ring_state #(
    .CODE_W   (CODE_W),
    .MAX_CODE (MAX_CODE),
    .MIN_LOG2 (MIN_LOG2)
  ) u_state (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .base_hi_i (cfg_base_hi_i),
    .base_lo_i (cfg_base_lo_i),
    .code_i    (cfg_size_i),
    .index_i   (cfg_index_i),
    .gen_i     (cfg_gen_i),
    .commit_i  (commit),
    .base_o    (base),
    .index_o   (index),
    .gen_o     (gen)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     data_q <= '0;
    else if (accept) data_q <= push_data_i;
  end

  evq_entry_fmt #(.IDX_W(IDX_W)) u_fmt (
    .base_i  (base),
    .index_i (index),
    .gen_i   (gen),
    .data_i  (data_q),
    .addr_o  (mem_addr_o),
    .wdata_o (mem_data_o)
  );

  a_r9_beat_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ready_i) |=> ($stable(mem_addr_o) && $stable(mem_data_o)));

  a_r8_err_keeps_ring: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_err_o |-> ($stable(index) && $stable(gen)));

  a_r11_no_load_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o && !$past(mem_ready_i)) |-> $stable(base));
endmodule

// File: tb/evq_writer_tb_top.sv
`timescale 1ns/1ps
module evq_writer_tb_top;
  localparam int IDX_W = 15;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [27:0] cfg_base_hi_i = '0;
  logic [31:0] cfg_base_lo_i = '0;
  logic [3:0]  cfg_size_i = '0;
  logic [IDX_W-1:0] cfg_index_i = '0;
  logic        cfg_gen_i = 1'b0;
  logic        push_i = 1'b0;
  logic [30:0] push_data_i = '0;
  logic        busy_o, mem_req_o, done_o, done_err_o;
  logic [59:0] mem_addr_o;
  logic [31:0] mem_data_o;
  logic        mem_ready_i = 1'b0;
  logic        mem_err_i = 1'b0;

  evq_writer dut_i (.*);

  always #4 clk_i = ~clk_i;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  // reference ring model
  logic [59:0] m_base = '0;
  int          m_code = 0;
  int          m_idx  = 0;
  bit          m_gen  = 0;

  // memory responder
  int          resp_lat = 0;
  bit          resp_err = 0;
  int          hs_cnt = 0;
  logic [59:0] cap_addr, first_addr;
  logic [31:0] cap_data, first_data;
  bit          in_req = 0;
  int          wait_cnt = 0;

  initial begin
    forever begin
      @(negedge clk_i);
      if (mem_req_o && !mem_ready_i) begin
        if (!in_req) begin
          in_req = 1; first_addr = mem_addr_o; first_data = mem_data_o; wait_cnt = 0;
        end
        if (wait_cnt >= resp_lat) begin
          mem_ready_i = 1'b1; mem_err_i = resp_err;
          cap_addr = mem_addr_o; cap_data = mem_data_o;
          hs_cnt++; in_req = 0;
        end else wait_cnt++;
      end else begin
        mem_ready_i = 1'b0; mem_err_i = 1'b0;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int entries(input int code);
    int c = (code > 5) ? 5 : code;
    return 1 << (c + 10);
  endfunction

  function automatic logic [31:0] swap(input logic [31:0] r);
    return {r[7:0], r[15:8], r[23:16], r[31:24]};
  endfunction

  task automatic load_cfg(input logic [27:0] hi, input logic [31:0] lo, input int code,
                          input int idx, input bit g);
    @(negedge clk_i);
    cfg_we_i = 1; cfg_base_hi_i = hi; cfg_base_lo_i = lo;
    cfg_size_i = 4'(code); cfg_index_i = IDX_W'(idx); cfg_gen_i = g;
    @(negedge clk_i);
    cfg_we_i = 0;
    m_base = {hi, lo}; m_code = code;
    m_idx = idx % entries(code); m_gen = g;
  endtask

  // intrude: pulse push_i and cfg_we_i while busy (R2, R11)
  task automatic do_push(input logic [30:0] d, input bit err, input int lat, input bit intrude);
    int start = hs_cnt;
    int guard = 0;
    logic [59:0] ea = m_base + 60'(m_idx) * 60'd4;
    logic [31:0] ed = swap({m_gen, d});
    resp_lat = lat; resp_err = err;
    @(negedge clk_i);
    push_i = 1; push_data_i = d;
    @(negedge clk_i);
    push_i = 0;
    chk(busy_o == 1'b1, "R9 busy after accept", 64'(busy_o), 64'd1);
    if (intrude && !done_o) begin
      push_i = 1; push_data_i = ~d;
      cfg_we_i = 1; cfg_index_i = IDX_W'(m_idx + 7); cfg_base_lo_i = 32'h5555_0000;
      @(negedge clk_i);
      push_i = 0; cfg_we_i = 0;
    end
    while (!done_o && guard < 100) begin @(negedge clk_i); guard++; end
    chk(done_o == 1'b1, "R10 done pulse", 64'(done_o), 64'd1);
    chk(done_err_o == err, "R10 done_err", 64'(done_err_o), 64'(err));
    chk(busy_o == 1'b0, "R9 busy drop", 64'(busy_o), 64'd0);
    chk(hs_cnt == start + 1, "R2 single write", 64'(hs_cnt - start), 64'd1);
    chk(cap_addr == ea, "R4 address", 64'(cap_addr), 64'(ea));
    chk(cap_data == ed, "R3 record", 64'(cap_data), 64'(ed));
    chk(first_addr == cap_addr && first_data == cap_data, "R9 held beat",
        64'(first_addr), 64'(cap_addr));
    @(negedge clk_i);
    chk(done_o == 1'b0, "R10 one cycle", 64'(done_o), 64'd0);
    chk(hs_cnt == start + 1, "R2 no extra write", 64'(hs_cnt - start), 64'd1);
    if (!err) begin
      m_idx = (m_idx + 1) % entries(m_code);
      if (m_idx == 0) m_gen = ~m_gen;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk(busy_o == 0 && mem_req_o == 0, "R1 reset idle", {busy_o, mem_req_o}, 0);
    chk(done_o == 0 && done_err_o == 0, "R1 reset done", {done_o, done_err_o}, 0);
    rst_ni = 1;
    @(negedge clk_i);
    chk(busy_o == 0, "R1 idle after release", 64'(busy_o), 0);
    // R1: reset ring state seen through first write
    do_push(31'h1234_5678, 0, 0, 0);
    do_push(31'h7FFF_FFFF, 0, 2, 0);

    // R4 carry into upper base bits, R7 wrap near end of ring
    load_cfg(28'hABCDEF1, 32'hFFFF_FF00, 0, 1020, 1);
    for (int i = 0; i < 7; i++) do_push(31'(32'h0100_0000 * i + i), 0, i % 3, 0);

    // R6 R7: a full lap plus one of the smallest ring
    load_cfg(28'h0000123, 32'h0000_0010, 0, 0, 0);
    for (int i = 0; i < 1026; i++) do_push(31'(i * 32'h9E37_79B9), 0, 0, 0);

    // R8: failed write keeps slot and generation, including at the last slot
    load_cfg(28'h0FEDCBA, 32'h8000_0000, 1, 2047, 0);
    do_push(31'h0AAA_5555, 1, 1, 0);
    do_push(31'h0AAA_5555, 1, 0, 0);
    do_push(31'h0AAA_5555, 0, 0, 0);
    do_push(31'h1111_2222, 1, 3, 0);
    do_push(31'h1111_2222, 0, 0, 0);

    // R2 R11: push and config pulses while busy are ignored
    do_push(31'h2468_ACE0, 0, 6, 1);
    do_push(31'h1357_9BDF, 0, 0, 0);
    cfg_base_lo_i = 32'h8000_0000;

    // R2 R11: config and push in the same idle cycle -> config wins
    @(negedge clk_i);
    cfg_we_i = 1; push_i = 1; push_data_i = 31'h3;
    cfg_base_hi_i = 28'h0000001; cfg_base_lo_i = 32'h0; cfg_size_i = 4'd0;
    cfg_index_i = IDX_W'(5); cfg_gen_i = 1;
    @(negedge clk_i);
    cfg_we_i = 0; push_i = 0;
    chk(busy_o == 0, "R2 push lost to config", 64'(busy_o), 0);
    m_base = {28'h0000001, 32'h0}; m_code = 0; m_idx = 5; m_gen = 1;
    do_push(31'h4, 0, 0, 0);

    // R5 R11: every size code, index loaded as all ones (masked to the ring)
    for (int c = 0; c < 16; c++) begin
      if (c > 6 && c != 15) continue;
      load_cfg(28'h0C0FFEE, 32'h0001_0000, c, (1 << IDX_W) - 1, 0);
      chk(m_idx == entries(c) - 1, "R5 model", 64'(m_idx), 64'(entries(c) - 1));
      do_push(31'(c), 0, 0, 0);  // last slot
      do_push(31'(c + 100), 0, 0, 0);  // wraps to slot 0, gen 1
      do_push(31'(c + 200), 0, 1, 0);
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule